// File: doc/BRIEF.md
# Biphase-Mark Stereo Audio Line Transmitter

This block accepts stereo audio as a serial bit stream, with one data line, a bit-rate strobe and a channel-select frame sync, and drives a single biphase-mark coded digital audio line. The serial input can be left-justified, I2S or right-justified. The sample width can be 16, 18, 20 or 24 bits. Each finished sample is held per channel until the output side picks it up.

The output side runs from its own half-bit strobe. It builds 32-slot subframes: a 4-slot preamble, 24 audio slots, a validity slot, a user slot, a channel-status slot and a parity slot. It codes each data slot as two half-bits. A 192-entry channel-status store is loaded through a simple write port, and frame n of every 192-frame block carries entry n. Both input strobes are one-cycle enables in the block's single clock domain. All state is cleared by a synchronous active-high reset.

Top module: `bmc_audio_tx`

## Requirements
- R1: After reset the line is low, and the first subframe sent is a left subframe of frame 0, which opens with the block-start preamble.
- R2: With fmt_sel=0 (left-justified), the MSB of a word is the bit sampled on the first bit strobe after fs_in changes level. The LSB is the bit sampled W-1 strobes later, where W is the selected width.
- R3: With fmt_sel=1 (I2S), the MSB is the bit sampled one strobe after the first strobe at the new fs_in level. The LSB follows W-1 strobes after the MSB.
- R4: With fmt_sel=2 (right-justified), the LSB is the bit sampled on the 32nd strobe of a 32-strobe half-frame. The W bits ending there form the word. In every format, bits outside the word window have no effect on the output.
- R5: width_sel 0, 1, 2 and 3 select 16, 18, 20 and 24 bits. The word is MSB-aligned in the 24 audio slots, the unused low slots are zero, and the audio slots are sent LSB first (slot 4 holds audio bit 0).
- R6: A word received while fs_in is low goes to the left subframe (first in each frame). A word received while fs_in is high goes to the right subframe.
- R7: The preamble half-bit patterns, first half-bit leftmost, are 11101000 for the block start (left subframe of frame 0), 11100010 for other left subframes and 11100100 for right subframes. The line is low whenever a preamble starts. Frame numbers count 0 to 191 and then wrap.
- R8: In slots 4 to 31 the line inverts at the start of every slot, and inverts again at mid-slot when the slot's bit is 1.
- R9: The validity slot (28) and the user slot (29) always carry 0.
- R10: The channel-status slot (30) of both subframes of frame n carries the bit last written to store address n through cs_we/cs_waddr/cs_wdata. Writes to addresses 192 and above are ignored.
- R11: The parity slot (31) makes the number of ones in slots 4 to 31 even.
- R12: The line changes only on clock edges where half_stb is high. One half-bit is emitted per half_stb. The sample and channel-status bit of a subframe are taken when its fifth preamble half-bit is emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 2 | Serial input format: 0 left-justified, 1 I2S, 2 right-justified |
| width_sel | input | 2 | Word width: 0=16, 1=18, 2=20, 3=24 bits |
| bit_stb | input | 1 | One-cycle strobe marking a valid serial bit |
| fs_in | input | 1 | Frame sync level, low for left and high for right |
| sd_in | input | 1 | Serial data, sampled with bit_stb |
| half_stb | input | 1 | One-cycle strobe advancing the output by one half-bit |
| cs_we | input | 1 | Channel-status store write enable |
| cs_waddr | input | 8 | Channel-status store address (frame number) |
| cs_wdata | input | 1 | Channel-status bit to store |
| spdif_out | output | 1 | Biphase-mark coded line output (registered) |

## Verification
The bench stresses the word-window edges in each format. It puts random junk in every bit outside the window. A design that counts from the wrong edge, or off by one strobe, lets junk into the audio slots or drops the MSB. Each width is run against the formats, so a wrong alignment shift shows up as audio landing in the wrong slots or low slots that are not zero. The run covers more than 192 frames, so a block counter that wraps at the wrong point sends the block-start preamble in the wrong frame or sends the wrong channel-status bit. A final stretch with the half-bit strobe held off catches an output that moves on its own.

// File: rtl/bmc_tx_pkg.sv
package bmc_tx_pkg;

  // serial input format codes
  typedef enum logic [1:0] {
    FMT_LJ  = 2'd0,
    FMT_I2S = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_RSV = 2'd3   // reserved, treated as left-justified
  } fmt_e;

  // number of preamble half-bits and subframe position where payload is taken
  localparam int PRE_HALVES = 8;
  localparam int LATCH_POS  = 4;

  // half-bit patterns, first half-bit in bit 7, for a line that was low
  localparam logic [7:0] PRE_BLOCK = 8'b1110_1000;
  localparam logic [7:0] PRE_LEFT  = 8'b1110_0010;
  localparam logic [7:0] PRE_RIGHT = 8'b1110_0100;

  // word width selected by the two-bit width code
  function automatic int unsigned wid_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 18;
      2'd2:    return 20;
      default: return 24;
    endcase
  endfunction

endpackage

// File: rtl/bmc_tx_deser.sv
module bmc_tx_deser
  import bmc_tx_pkg::*;
#(
  parameter int SAMPLE_W   = 24,
  parameter int HALF_SLOTS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          fmt,
  input  logic [1:0]          wsel,
  input  logic                bit_stb,
  input  logic                fs,
  input  logic                sd,
  output logic [SAMPLE_W-1:0] hold_l,
  output logic [SAMPLE_W-1:0] hold_r
);

  localparam int CNT_W = $clog2(HALF_SLOTS) + 1;
  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  logic                fs_d;
  logic [CNT_W-1:0]    cnt_q, cnt_n, end_idx;
  logic [SAMPLE_W-2:0] sr_q;
  logic [SAMPLE_W-1:0] word, aligned;
  logic                grab;
  int unsigned         wbits;

  always_comb begin
    wbits = wid_bits(wsel);
    case (fmt)
      FMT_I2S: end_idx = CNT_W'(wbits);
      FMT_RJ:  end_idx = CNT_W'(HALF_SLOTS - 1);
      default: end_idx = CNT_W'(wbits - 1);
    endcase
    // position within the half-frame, restarted at each frame-sync level change
    if (fs != fs_d)            cnt_n = '0;
    else if (cnt_q == CNT_SAT) cnt_n = CNT_SAT;
    else                       cnt_n = cnt_q + 1'b1;
    word    = {sr_q, sd};
    aligned = word << (SAMPLE_W - wbits);
    grab    = bit_stb && (cnt_n == end_idx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_d   <= 1'b1;   // right level, so a stream opening with left is seen as an edge
      cnt_q  <= CNT_SAT;
      sr_q   <= '0;
      hold_l <= '0;
      hold_r <= '0;
    end else if (bit_stb) begin
      fs_d  <= fs;
      cnt_q <= cnt_n;
      sr_q  <= word[SAMPLE_W-2:0];
      if (grab) begin
        if (fs) hold_r <= aligned;
        else    hold_l <= aligned;
      end
    end
  end

endmodule

// File: rtl/bmc_tx_csram.sv
module bmc_tx_csram #(
  parameter int DEPTH = 192,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic mem [DEPTH];

  // one write port, one registered read port
  always_ff @(posedge clk) begin
    if (we && (waddr <= LAST)) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/bmc_tx_framer.sv
module bmc_tx_framer
  import bmc_tx_pkg::*;
#(
  parameter int SAMPLE_W     = 24,
  parameter int BLOCK_FRAMES = 192,
  parameter int FAW          = $clog2(BLOCK_FRAMES),
  parameter int PAY_W        = SAMPLE_W + 4,
  parameter int POS_W        = $clog2(2 * (PAY_W + 4))
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                half_stb,
  input  logic [SAMPLE_W-1:0] hold_l,
  input  logic [SAMPLE_W-1:0] hold_r,
  input  logic                cs_bit,
  output logic [FAW-1:0]      frame_q,
  output logic [POS_W-1:0]    pos_q,
  output logic [PAY_W-1:0]    pay_q,
  output logic                cmd_pre,
  output logic                cmd_lvl,
  output logic                cmd_first,
  output logic                cmd_bit
);

  localparam int HALVES = 2 * (PAY_W + 4);

  logic                sub_q;
  logic [PAY_W-1:0]    pay_n, pay_sh;
  logic [7:0]          pre_sel;
  logic [POS_W-2:0]    pay_idx;
  logic [SAMPLE_W-1:0] smp;

  // payload: audio LSB first, then validity, user, channel status, parity
  always_comb begin
    smp                    = sub_q ? hold_r : hold_l;
    pay_n                  = '0;
    pay_n[SAMPLE_W-1:0]    = smp;
    pay_n[SAMPLE_W]        = 1'b0;
    pay_n[SAMPLE_W+1]      = 1'b0;
    pay_n[SAMPLE_W+2]      = cs_bit;
    pay_n[SAMPLE_W+3]      = ^pay_n[SAMPLE_W+2:0];
  end

  // half-bit command for the line stage
  always_comb begin
    if (sub_q)                pre_sel = PRE_RIGHT;
    else if (frame_q == '0)   pre_sel = PRE_BLOCK;
    else                      pre_sel = PRE_LEFT;
    cmd_pre   = pos_q < POS_W'(PRE_HALVES);
    cmd_lvl   = pre_sel[3'd7 - pos_q[2:0]];
    cmd_first = ~pos_q[0];
    pay_idx   = pos_q[POS_W-1:1] - (POS_W-1)'(PRE_HALVES / 2);
    pay_sh    = pay_q >> pay_idx;
    cmd_bit   = pay_sh[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= '0;
      sub_q   <= 1'b0;
      frame_q <= '0;
      pay_q   <= '0;
    end else if (half_stb) begin
      if (pos_q == POS_W'(LATCH_POS)) pay_q <= pay_n;
      if (pos_q == POS_W'(HALVES - 1)) begin
        pos_q <= '0;
        sub_q <= ~sub_q;
        if (sub_q) begin
          if (frame_q == FAW'(BLOCK_FRAMES - 1)) frame_q <= '0;
          else                                   frame_q <= frame_q + 1'b1;
        end
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/bmc_tx_line.sv
module bmc_tx_line (
  input  logic clk,
  input  logic rst,
  input  logic half_stb,
  input  logic cmd_pre,
  input  logic cmd_lvl,
  input  logic cmd_first,
  input  logic cmd_bit,
  output logic line_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b0;
    end else if (half_stb) begin
      if (cmd_pre)        line_q <= cmd_lvl;
      else if (cmd_first) line_q <= ~line_q;
      else                line_q <= line_q ^ cmd_bit;
    end
  end

endmodule

// File: rtl/bmc_audio_tx.sv
module bmc_audio_tx #(
  parameter int SAMPLE_W     = 24,
  parameter int HALF_SLOTS   = 32,
  parameter int BLOCK_FRAMES = 192,
  parameter int FAW          = $clog2(BLOCK_FRAMES)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     fmt_sel,
  input  logic [1:0]     width_sel,
  input  logic           bit_stb,
  input  logic           fs_in,
  input  logic           sd_in,
  input  logic           half_stb,
  input  logic           cs_we,
  input  logic [FAW-1:0] cs_waddr,
  input  logic           cs_wdata,
  output logic           spdif_out
);

  localparam int PAY_W  = SAMPLE_W + 4;
  localparam int HALVES = 2 * (PAY_W + 4);
  localparam int POS_W  = $clog2(HALVES);

  logic [SAMPLE_W-1:0] hold_l, hold_r;
  logic                cs_bit;
  logic [FAW-1:0]      frm_frame;
  logic [POS_W-1:0]    frm_pos;
  logic [PAY_W-1:0]    frm_pay;
  logic                cmd_pre, cmd_lvl, cmd_first, cmd_bit;

  bmc_tx_deser #(.SAMPLE_W(SAMPLE_W), .HALF_SLOTS(HALF_SLOTS)) u_deser (
    .clk(clk), .rst(rst), .fmt(fmt_sel), .wsel(width_sel),
    .bit_stb(bit_stb), .fs(fs_in), .sd(sd_in),
    .hold_l(hold_l), .hold_r(hold_r)
  );

  bmc_tx_csram #(.DEPTH(BLOCK_FRAMES), .AW(FAW)) u_cs (
    .clk(clk), .we(cs_we), .waddr(cs_waddr), .wdata(cs_wdata),
    .raddr(frm_frame), .rdata(cs_bit)
  );

  bmc_tx_framer #(
    .SAMPLE_W(SAMPLE_W), .BLOCK_FRAMES(BLOCK_FRAMES), .FAW(FAW),
    .PAY_W(PAY_W), .POS_W(POS_W)
  ) u_frm (
    .clk(clk), .rst(rst), .half_stb(half_stb),
    .hold_l(hold_l), .hold_r(hold_r), .cs_bit(cs_bit),
    .frame_q(frm_frame), .pos_q(frm_pos), .pay_q(frm_pay),
    .cmd_pre(cmd_pre), .cmd_lvl(cmd_lvl), .cmd_first(cmd_first), .cmd_bit(cmd_bit)
  );

  bmc_tx_line u_line (
    .clk(clk), .rst(rst), .half_stb(half_stb),
    .cmd_pre(cmd_pre), .cmd_lvl(cmd_lvl), .cmd_first(cmd_first), .cmd_bit(cmd_bit),
    .line_q(spdif_out)
  );

endmodule

// File: rtl/bmc_audio_tx_chk.sv
module bmc_audio_tx_chk #(
  parameter int POS_W        = 6,
  parameter int PAY_W        = 28,
  parameter int FAW          = 8,
  parameter int BLOCK_FRAMES = 192
) (
  input logic             clk,
  input logic             rst,
  input logic             half_stb,
  input logic             line,
  input logic [POS_W-1:0] pos,
  input logic [PAY_W-1:0] pay,
  input logic [FAW-1:0]   frame
);

  p_still_r12: assert property (@(posedge clk) disable iff (rst)
    !half_stb |=> $stable(line));

  p_slot_edge_r8: assert property (@(posedge clk) disable iff (rst)
    (half_stb && pos >= POS_W'(8) && !pos[0]) |=> (line != $past(line)));

  p_pre_low_r7: assert property (@(posedge clk) disable iff (rst)
    (half_stb && pos == '0) |-> !line);

  p_even_r11: assert property (@(posedge clk) disable iff (rst)
    (half_stb && pos == POS_W'(8)) |-> !(^pay));

  p_vu_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (half_stb && pos == POS_W'(8)) |-> (pay[PAY_W-4] == 1'b0 && pay[PAY_W-3] == 1'b0));

  p_frame_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    frame < FAW'(BLOCK_FRAMES));

endmodule

bind bmc_audio_tx bmc_audio_tx_chk #(
  .POS_W(POS_W), .PAY_W(PAY_W), .FAW(FAW), .BLOCK_FRAMES(BLOCK_FRAMES)
) u_chk (
  .clk(clk), .rst(rst), .half_stb(half_stb), .line(spdif_out),
  .pos(frm_pos), .pay(frm_pay), .frame(frm_frame)
);

// File: tb/sim_bmc_audio_tx.sv
module sim_bmc_audio_tx;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] fmt_sel = 2'd0, width_sel = 2'd3;
  logic       bit_stb = 1'b0, fs_in = 1'b1, sd_in = 1'b0;
  logic       half_stb = 1'b0;
  logic       cs_we = 1'b0, cs_wdata = 1'b0;
  logic [7:0] cs_waddr = '0;
  logic       spdif_out;

  int errors = 0, checks = 0;
  bit done = 0;
  bit run_ht = 0;
  int ht_cnt = 0;

  // stimulus side info consumed by the model
  int          cur_idx = 0, cur_ch = 0;
  logic [23:0] cur_aligned = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bmc_audio_tx u0 (
    .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .width_sel(width_sel),
    .bit_stb(bit_stb), .fs_in(fs_in), .sd_in(sd_in), .half_stb(half_stb),
    .cs_we(cs_we), .cs_waddr(cs_waddr), .cs_wdata(cs_wdata),
    .spdif_out(spdif_out)
  );

  function automatic int width_of(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 18 : (c == 2'd2) ? 20 : 24;
  endfunction

  function automatic int last_idx(input logic [1:0] f, input logic [1:0] c);
    if (f == 2'd1) return width_of(c);      // I2S
    if (f == 2'd2) return 31;               // right-justified
    return width_of(c) - 1;                 // left-justified
  endfunction

  // ---------------- reference model ----------------
  logic        m_line;
  int          m_pos, m_sub, m_frame;
  logic [23:0] m_hold [2];
  logic        m_cs [256];
  bit          m_q [$];
  bit          saw_ht;
  int          t_pos;
  logic [1:0]  t_fmt;

  always @(posedge clk) begin
    logic [7:0] pre;
    bit b, par;
    if (rst) begin
      m_line = 1'b0; m_pos = 0; m_sub = 0; m_frame = 0;
      m_hold[0] = '0; m_hold[1] = '0; m_q.delete(); saw_ht = 0; t_pos = 0;
    end else begin
      if (half_stb) begin
        saw_ht = 1; t_pos = m_pos; t_fmt = fmt_sel;
        if (m_pos < 8) begin
          pre = (m_sub == 1) ? 8'b11100100 : (m_frame == 0) ? 8'b11101000 : 8'b11100010;
          m_line = pre[7 - m_pos];
        end else if (m_pos % 2 == 0) begin
          m_line = ~m_line;
        end else begin
          b = m_q.pop_front();
          if (b) m_line = ~m_line;
        end
        if (m_pos == 4) begin
          m_q.delete(); par = 0;
          for (int k = 0; k < 24; k++) begin
            b = m_hold[m_sub][k]; m_q.push_back(b); par ^= b;
          end
          m_q.push_back(1'b0); m_q.push_back(1'b0);
          b = m_cs[m_frame]; m_q.push_back(b); par ^= b;
          m_q.push_back(par);
        end
        m_pos++;
        if (m_pos == 64) begin
          m_pos = 0;
          if (m_sub == 1) begin m_sub = 0; m_frame = (m_frame + 1) % 192; end
          else m_sub = 1;
        end
      end else begin
        saw_ht = 0;
      end
      if (bit_stb && cur_idx == last_idx(fmt_sel, width_sel)) m_hold[cur_ch] = cur_aligned;
      if (cs_we && cs_waddr < 8'd192) m_cs[cs_waddr] = cs_wdata;
    end
  end

  function automatic string tag_of();
    int s;
    if (!saw_ht) return "R12 line held";
    if (t_pos < 8) return "R1/R7 preamble";
    s = t_pos / 2;
    if (s == 28 || s == 29) return "R9 validity/user";
    if (s == 30) return "R10 channel status";
    if (s == 31) return "R11 parity";
    if (t_fmt == 2'd1) return "R3 R5 R6 R8 audio I2S";
    if (t_fmt == 2'd2) return "R4 R5 R6 R8 audio right-justified";
    return "R2 R5 R6 R8 audio left-justified";
  endfunction

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (spdif_out !== m_line) begin
        errors++;
        $display("FAIL %s: spdif_out=%0b expected=%0b (pos %0d, t=%0t)",
                 tag_of(), spdif_out, m_line, t_pos, $time);
      end
    end
  end

  // half-bit strobe: every other clock while running
  always @(negedge clk) begin
    ht_cnt++;
    half_stb <= run_ht && (ht_cnt % 2 == 0);
  end

  task automatic send_frame(input int w);
    logic [23:0] word;
    bit v;
    for (int ch = 0; ch < 2; ch++) begin
      word = 24'($urandom) & ((24'd1 << w) - 24'd1);
      for (int i = 0; i < 32; i++) begin
        v = 1'($urandom);                               // junk outside the window
        if (fmt_sel == 2'd1) begin
          if (i >= 1 && i <= w) v = word[w - i];
        end else if (fmt_sel == 2'd2) begin
          if (i >= 32 - w) v = word[31 - i];
        end else begin
          if (i < w) v = word[w - 1 - i];
        end
        @(negedge clk);
        fs_in = 1'(ch); sd_in = v; cur_idx = i; cur_ch = ch;
        cur_aligned = word << (24 - w);
        bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
        repeat (2) @(negedge clk);
      end
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic [1:0] fl [6];
    logic [1:0] wl [6];
    fl = '{2'd0, 2'd1, 2'd2, 2'd0, 2'd2, 2'd1};
    wl = '{2'd3, 2'd0, 2'd2, 2'd1, 2'd3, 2'd3};
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;                                   // R1: reset level
    if (spdif_out !== 1'b0) begin
      errors++; $display("FAIL R1 reset: spdif_out=%0b expected=0", spdif_out);
    end
    // R10: load channel status, including an ignored out-of-range address
    for (int a = 0; a < 192; a++) begin
      cs_we = 1'b1; cs_waddr = 8'(a); cs_wdata = 1'($urandom);
      @(negedge clk);
    end
    cs_waddr = 8'd200; cs_wdata = 1'b1;
    @(negedge clk);
    cs_we = 1'b0;
    run_ht = 1;
    for (int sc = 0; sc < 6; sc++) begin
      fmt_sel = fl[sc]; width_sel = wl[sc];
      for (int f = 0; f < 34; f++) send_frame(width_of(wl[sc]));
    end
    run_ht = 0;
    repeat (40) @(negedge clk);                 // R12: line must stay put
    done = 1;
    summary();
  end

endmodule